// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out the atomic memory instructions of a 64-bit register-machine bytecode as one locked read-modify-write on a synchronous memory port. A decoder hands it an already-fetched instruction: the opcode byte, the 32-bit immediate that names the operation, the base register value, the signed 16-bit displacement, the operand register value, the current value of register zero, and the index of the operand register. The unit reads the target location, computes the new value, writes it back if needed, and on completion tells the register file which register to update with the old memory contents.

The operation lives in the low byte of the immediate, not in the opcode. Bit 0 of that byte asks for the old value to be returned. Exchange and compare-and-swap always return it. Compare-and-swap uses register zero both as the expected value and as the place where the old value goes. The lock output stays high from the read through the write so that an arbiter outside the block lets no other access in between. Bad encodings and unaligned addresses finish at once with an error flag and no memory access.

Top module: `amo_seq_unit`

## Requirements
- R1: A request is taken only while `busy` is low. `busy` stays high from the cycle after acceptance through the cycle where `done` pulses, and `req_valid` has no effect while `busy` is high. After reset `busy`, `done`, `mem_en` and `mem_lock` are low.
- R2: Legal opcodes are 0xc3 (32-bit) and 0xdb (64-bit). Opcode bits [2:0] must be 3, bits [7:5] must be 6, and bits [4:3] must be 00 (word) or 11 (double word). Any other opcode, including the halfword and byte sizes 0xcb and 0xd3, raises `err_illegal` with `done`. In that case there is no memory access and no writeback.
- R3: Legal immediates are 0x00 add, 0x40 or, 0x50 and, 0xa0 xor, each with or without bit 0 set, plus 0xe1 exchange and 0xf1 compare-and-swap. Bits [31:8] must be zero. Any other value, including 0xe0 and 0xf0, is illegal and handled as in R2.
- R4: The address is `req_base` plus the sign-extended `req_off`. If a word access is not 4-byte aligned, or a double-word access is not 8-byte aligned, the unit raises `err_misalign` with `done` and makes no memory access.
- R5: A legal request drives a read in the first cycle after acceptance, uses the read data in the second, and writes in the third. `done` pulses in the fourth. `mem_lock` is high for exactly those three cycles. A faulting request pulses `done` in the first cycle after acceptance.
- R6: Add, or, and and xor store `old op operand`. For a word access only the low 32 bits of the operand are used, the write is 32 bits wide, and the other half of the 64-bit line keeps its value. For a word access, read data and write data sit in bits [31:0] of the port.
- R7: If bit 0 of the immediate is set on add, or, and, xor or exchange, then `wb_en` is high with `done`, `wb_idx` equals `req_src_idx`, and `wb_data` is the old memory value, zero-extended. If bit 0 is clear, `wb_en` stays low.
- R8: Exchange stores the operand and returns the old value as in R7.
- R9: Compare-and-swap stores the operand only if the old value equals `req_r0`. A word access compares only the low 32 bits. If the values differ, nothing is written. In both cases `wb_idx` is 0 and `wb_data` is the zero-extended old value.
- R10: If a request is both illegal and misaligned, only `err_illegal` is reported. `wb_en` is never high together with an error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_opcode | input | 8 | Instruction opcode byte |
| req_imm | input | 32 | Immediate selecting the operation |
| req_base | input | XLEN | Base register value |
| req_off | input | 16 | Signed displacement |
| req_src | input | XLEN | Operand register value |
| req_r0 | input | XLEN | Register zero value (compare operand) |
| req_src_idx | input | RIDX_W | Index of the operand register |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_dw | output | 1 | 64-bit access when high, 32-bit when low |
| mem_lock | output | 1 | Port held from read through write |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid the cycle after a read strobe |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register writeback valid |
| wb_idx | output | RIDX_W | Register to update |
| wb_data | output | XLEN | Old memory value, zero-extended |
| err_illegal | output | 1 | Illegal encoding, valid with done |
| err_misalign | output | 1 | Unaligned address, valid with done |

## Verification
Two things can land on the same cycle: a new request, and the write or completion of the one in flight, while the unit still holds the memory lock. The bench provokes this by raising `req_valid` with a different target during the write cycle and again during the completion cycle. It then checks that only one completion is seen and that the second target's memory line is unchanged. The other collision is a request that is both illegal and unaligned. There the bench checks that the illegal flag alone is reported, with no memory traffic.

// File: rtl/amo_pkg.sv
package amo_pkg;

   localparam logic [2:0] CLS_STORE_REG = 3'd3;
   localparam logic [2:0] MODE_ATOMIC   = 3'd6;
   localparam logic [1:0] SZ_WORD       = 2'b00;
   localparam logic [1:0] SZ_DWORD      = 2'b11;

   localparam logic [7:0] IMM_ADD  = 8'h00;
   localparam logic [7:0] IMM_OR   = 8'h40;
   localparam logic [7:0] IMM_AND  = 8'h50;
   localparam logic [7:0] IMM_XOR  = 8'ha0;
   localparam logic [7:0] IMM_XCHG = 8'he0;
   localparam logic [7:0] IMM_CMPX = 8'hf0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_MODIFY,
      ST_WRITE,
      ST_DONE
   } amo_state_e;

   typedef enum logic [2:0] {
      OP_ADD,
      OP_OR,
      OP_AND,
      OP_XOR,
      OP_XCHG,
      OP_CMPX
   } amo_op_e;

   typedef struct packed {
      amo_op_e op;
      logic    fetch;
      logic    dw;
      logic    illegal;
   } amo_dec_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
#(
   parameter bit SUPPORT_DW = 1'b1
) (
   input  logic [7:0]  opcode,
   input  logic [31:0] imm,
   output amo_dec_t    dec
);

   logic [2:0] cls;
   logic [2:0] mode;
   logic [1:0] sz;
   logic       size_ok;
   logic       imm_ok;
   logic [7:0] imm_base;

   assign cls      = opcode[2:0];
   assign mode     = opcode[7:5];
   assign sz       = opcode[4:3];
   assign imm_base = {imm[7:1], 1'b0};

   generate
      if (SUPPORT_DW) begin : g_both_sizes
         assign size_ok = (sz == SZ_WORD) || (sz == SZ_DWORD);
      end else begin : g_word_only
         assign size_ok = (sz == SZ_WORD);
      end
   endgenerate

   always_comb begin
      dec       = '0;
      dec.op    = OP_ADD;
      dec.fetch = imm[0];
      dec.dw    = (sz == SZ_DWORD);
      imm_ok    = 1'b1;
      case (imm_base)
         IMM_ADD:  dec.op = OP_ADD;
         IMM_OR:   dec.op = OP_OR;
         IMM_AND:  dec.op = OP_AND;
         IMM_XOR:  dec.op = OP_XOR;
         IMM_XCHG: begin
            dec.op = OP_XCHG;
            imm_ok = imm[0];
         end
         IMM_CMPX: begin
            dec.op = OP_CMPX;
            imm_ok = imm[0];
         end
         default:  imm_ok = 1'b0;
      endcase
      dec.illegal = !((cls == CLS_STORE_REG) && (mode == MODE_ATOMIC) &&
                      size_ok && imm_ok && (imm[31:8] == 24'd0));
   end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  amo_op_e         op,
   input  logic            dw,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] operand,
   input  logic [XLEN-1:0] expect_val,
   output logic [XLEN-1:0] new_val,
   output logic            do_write
);

   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] opnd_m;
   logic [XLEN-1:0] raw;
   logic            match;

   assign opnd_m = dw ? operand : {{HALF{1'b0}}, operand[HALF-1:0]};
   assign match  = dw ? (old_val == expect_val)
                      : (old_val[HALF-1:0] == expect_val[HALF-1:0]);

   always_comb begin
      raw      = opnd_m;
      do_write = 1'b1;
      case (op)
         OP_ADD:  raw = old_val + opnd_m;
         OP_OR:   raw = old_val | opnd_m;
         OP_AND:  raw = old_val & opnd_m;
         OP_XOR:  raw = old_val ^ opnd_m;
         OP_XCHG: raw = opnd_m;
         OP_CMPX: begin
            raw      = opnd_m;
            do_write = match;
         end
         default: raw = opnd_m;
      endcase
   end

   assign new_val = dw ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};

endmodule

// File: rtl/amo_seq_fsm.sv
module amo_seq_fsm
   import amo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       fault,
   output amo_state_e state
);

   amo_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:   if (start) nxt = fault ? ST_DONE : ST_READ;
         ST_READ:   nxt = ST_MODIFY;
         ST_MODIFY: nxt = ST_WRITE;
         ST_WRITE:  nxt = ST_DONE;
         ST_DONE:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   a_r5_read_then_modify: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_READ |=> state == ST_MODIFY);
   a_r5_modify_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_MODIFY |=> state == ST_WRITE);
   a_r5_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WRITE |=> state == ST_DONE);

endmodule

// File: rtl/amo_seq_unit.sv
module amo_seq_unit
   import amo_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int RIDX_W     = 4,
   parameter bit SUPPORT_DW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_opcode,
   input  logic [31:0]       req_imm,
   input  logic [XLEN-1:0]   req_base,
   input  logic [15:0]       req_off,
   input  logic [XLEN-1:0]   req_src,
   input  logic [XLEN-1:0]   req_r0,
   input  logic [RIDX_W-1:0] req_src_idx,
   output logic              busy,
   output logic              mem_en,
   output logic              mem_we,
   output logic              mem_dw,
   output logic              mem_lock,
   output logic [XLEN-1:0]   mem_addr,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic              done,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_idx,
   output logic [XLEN-1:0]   wb_data,
   output logic              err_illegal,
   output logic              err_misalign
);

   localparam int HALF  = XLEN / 2;
   localparam int OFF_W = 16;

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("amo_seq_unit: XLEN must be 64");
      end
      if (RIDX_W < 4) begin : g_bad_ridx
         $error("amo_seq_unit: RIDX_W must hold 16 registers");
      end
   endgenerate

   amo_state_e state;
   amo_dec_t   dec_in;
   amo_dec_t   r_dec;

   logic [XLEN-1:0]   eff_addr;
   logic              misal;
   logic              accept;
   logic [XLEN-1:0]   r_addr, r_src, r_r0, r_old, r_new;
   logic [RIDX_W-1:0] r_idx;
   logic              r_ill, r_mis, r_wr;
   logic [XLEN-1:0]   old_ext, alu_new;
   logic              alu_wr;

   amo_decode #(.SUPPORT_DW(SUPPORT_DW)) u_dec (
      .opcode (req_opcode),
      .imm    (req_imm),
      .dec    (dec_in)
   );

   assign eff_addr = req_base + {{(XLEN-OFF_W){req_off[OFF_W-1]}}, req_off};
   assign misal    = dec_in.dw ? (eff_addr[2:0] != 3'd0) : (eff_addr[1:0] != 2'd0);
   assign accept   = req_valid && (state == ST_IDLE);

   amo_seq_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .fault (dec_in.illegal | misal),
      .state (state)
   );

   assign old_ext = r_dec.dw ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};

   amo_alu #(.XLEN(XLEN)) u_alu (
      .op         (r_dec.op),
      .dw         (r_dec.dw),
      .old_val    (old_ext),
      .operand    (r_src),
      .expect_val (r_r0),
      .new_val    (alu_new),
      .do_write   (alu_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_dec  <= '0;
         r_addr <= '0;
         r_src  <= '0;
         r_r0   <= '0;
         r_idx  <= '0;
         r_ill  <= 1'b0;
         r_mis  <= 1'b0;
         r_old  <= '0;
         r_new  <= '0;
         r_wr   <= 1'b0;
      end else begin
         if (accept) begin
            r_dec  <= dec_in;
            r_addr <= eff_addr;
            r_src  <= req_src;
            r_r0   <= req_r0;
            r_idx  <= req_src_idx;
            r_ill  <= dec_in.illegal;
            r_mis  <= !dec_in.illegal && misal;
            r_wr   <= 1'b0;
         end
         if (state == ST_MODIFY) begin
            r_old <= old_ext;
            r_new <= alu_new;
            r_wr  <= alu_wr;
         end
      end
   end

   assign busy      = (state != ST_IDLE);
   assign mem_lock  = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
   assign mem_we    = (state == ST_WRITE) && r_wr;
   assign mem_en    = (state == ST_READ) || mem_we;
   assign mem_dw    = r_dec.dw;
   assign mem_addr  = r_addr;
   assign mem_wdata = r_new;

   assign done         = (state == ST_DONE);
   assign err_illegal  = done && r_ill;
   assign err_misalign = done && r_mis;
   assign wb_en        = done && r_dec.fetch && !r_ill && !r_mis;
   assign wb_idx       = (r_dec.op == OP_CMPX) ? '0 : r_idx;
   assign wb_data      = r_old;

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_en && !done && !mem_lock));
   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> mem_lock);
   a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> $past(mem_en && !mem_we, 2));
   a_r4_dw_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_dw) |-> (mem_addr[2:0] == 3'd0));
   a_r4_w_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_dw) |-> (mem_addr[1:0] == 2'd0));
   a_r10_one_error: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(err_illegal && err_misalign));
   a_r10_no_wb_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (done && !err_illegal && !err_misalign));

endmodule

// File: tb/tb_amo_seq_unit.sv
`timescale 1ns/1ps
module tb_amo_seq_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_opcode = 8'h0;
   logic [31:0] req_imm = 32'h0;
   logic [63:0] req_base = 64'h0;
   logic [15:0] req_off = 16'h0;
   logic [63:0] req_src = 64'h0;
   logic [63:0] req_r0 = 64'h0;
   logic [3:0]  req_src_idx = 4'h0;
   logic        busy, mem_en, mem_we, mem_dw, mem_lock;
   logic [63:0] mem_addr, mem_wdata;
   logic [63:0] mem_rdata = 64'h0;
   logic        done, wb_en, err_illegal, err_misalign;
   logic [3:0]  wb_idx;
   logic [63:0] wb_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_cnt = 0;

   always #2.5 clk = ~clk;

   amo_seq_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
      .req_imm(req_imm), .req_base(req_base), .req_off(req_off), .req_src(req_src),
      .req_r0(req_r0), .req_src_idx(req_src_idx), .busy(busy), .mem_en(mem_en),
      .mem_we(mem_we), .mem_dw(mem_dw), .mem_lock(mem_lock), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data), .err_illegal(err_illegal),
      .err_misalign(err_misalign)
   );

   // bench memory: 16 lines of 64 bits, line = addr[6:3]
   logic [63:0] ram [16];
   logic        pre_we = 1'b0;
   logic [3:0]  pre_idx = 4'h0;
   logic [63:0] pre_data = 64'h0;

   always @(posedge clk) begin
      if (pre_we) ram[pre_idx] <= pre_data;
      else if (mem_en && mem_we) begin
         if (mem_dw) ram[mem_addr[6:3]] <= mem_wdata;
         else if (mem_addr[2]) ram[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
         else ram[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
      end
      if (mem_en && !mem_we) begin
         if (mem_dw) mem_rdata <= ram[mem_addr[6:3]];
         else mem_rdata <= {32'h0, mem_addr[2] ? ram[mem_addr[6:3]][63:32]
                                                : ram[mem_addr[6:3]][31:0]};
      end
   end

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt > 100000) begin
         n_bad = n_bad + 1;
         $display("FAIL R1 watchdog expired: got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk = n_chk + 1;
      if (got !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic preload(input logic [3:0] idx, input logic [63:0] val);
      @(negedge clk);
      pre_we = 1'b1; pre_idx = idx; pre_data = val;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   // results of the last operation
   int          r_cyc, r_lock;
   logic        r_wb_en, r_ill, r_mis;
   logic [3:0]  r_idx;
   logic [63:0] r_data;

   task automatic run_op(input logic [7:0] opc, input logic [31:0] imm,
                         input logic [63:0] base, input logic [15:0] off,
                         input logic [63:0] src, input logic [63:0] r0,
                         input logic [3:0] idx);
      @(negedge clk);
      req_opcode = opc; req_imm = imm; req_base = base; req_off = off;
      req_src = src; req_r0 = r0; req_src_idx = idx; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      r_cyc = 1; r_lock = 0;
      while (!done && r_cyc < 20) begin
         if (mem_lock) r_lock = r_lock + 1;
         @(negedge clk);
         r_cyc = r_cyc + 1;
      end
      r_wb_en = wb_en; r_idx = wb_idx; r_data = wb_data;
      r_ill = err_illegal; r_mis = err_misalign;
   endtask

   task automatic t_reset;
      chk("R1 reset busy", {63'h0, busy}, 64'h0);
      chk("R1 reset done", {63'h0, done}, 64'h0);
      chk("R1 reset mem_en", {63'h0, mem_en}, 64'h0);
      chk("R1 reset lock", {63'h0, mem_lock}, 64'h0);
   endtask

   task automatic t_add_dw;
      preload(4'd1, 64'h0000_0001_FFFF_FFFF);
      run_op(8'hdb, 32'h00, 64'h8, 16'h0, 64'h1, 64'h0, 4'd3);
      chk("R6 dw add line", ram[1], 64'h0000_0002_0000_0000);
      chk("R7 no fetch wb_en", {63'h0, r_wb_en}, 64'h0);
      chk("R5 legal latency", r_cyc, 4);
      chk("R5 lock cycles", r_lock, 3);
   endtask

   task automatic t_word_ops;
      preload(4'd2, 64'hAAAA_AAAA_FFFF_FFFF);
      run_op(8'hc3, 32'h01, 64'h10, 16'h0, 64'h0000_0005_0000_0001, 64'h0, 4'd7);
      chk("R6 word add low half", ram[2], 64'hAAAA_AAAA_0000_0000);
      chk("R7 fetch wb_en", {63'h0, r_wb_en}, 64'h1);
      chk("R7 fetch idx", {60'h0, r_idx}, 64'h7);
      chk("R7 fetch old zext", r_data, 64'h0000_0000_FFFF_FFFF);
      run_op(8'hc3, 32'h41, 64'h14, 16'h0, 64'h0000_0000_0000_0F0F, 64'h0, 4'd2);
      chk("R6 word or high half", ram[2], 64'hAAAA_AFAF_0000_0000);
      chk("R7 fetch old high half", r_data, 64'h0000_0000_AAAA_AAAA);
      run_op(8'hc3, 32'ha0, 64'h10, 16'h4, 64'hFFFF_FFFF_0000_FFFF, 64'h0, 4'd2);
      chk("R6 word xor via offset", ram[2], 64'hAAAA_5050_0000_0000);
   endtask

   task automatic t_dw_ops;
      preload(4'd7, 64'hF0F0_F0F0_1234_5678);
      run_op(8'hdb, 32'h51, 64'h40, 16'hFFF8, 64'h0FF0_0FF0_FFFF_0000, 64'h0, 4'd5);
      chk("R4 neg offset and", ram[7], 64'h00F0_00F0_1234_0000);
      chk("R7 dw old value", r_data, 64'hF0F0_F0F0_1234_5678);
      run_op(8'hdb, 32'ha0, 64'h38, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd5);
      chk("R6 dw xor", ram[7], 64'hFF0F_FF0F_EDCB_FFFF);
   endtask

   task automatic t_xchg;
      preload(4'd3, 64'h1111_2222_3333_4444);
      run_op(8'hdb, 32'he1, 64'h18, 16'h0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 4'd9);
      chk("R8 dw xchg line", ram[3], 64'hDEAD_BEEF_CAFE_F00D);
      chk("R8 dw xchg old", r_data, 64'h1111_2222_3333_4444);
      chk("R8 dw xchg idx", {60'h0, r_idx}, 64'h9);
      run_op(8'hc3, 32'he1, 64'h1C, 16'h0, 64'h9999_9999_0000_0042, 64'h0, 4'd4);
      chk("R8 word xchg line", ram[3], 64'h0000_0042_CAFE_F00D);
      chk("R8 word xchg old", r_data, 64'h0000_0000_DEAD_BEEF);
   endtask

   task automatic t_cmpx;
      preload(4'd4, 64'h0000_0000_0000_0055);
      run_op(8'hdb, 32'hf1, 64'h20, 16'h0, 64'h77, 64'h56, 4'd6);
      chk("R9 mismatch keeps line", ram[4], 64'h55);
      chk("R9 mismatch old to r0", r_data, 64'h55);
      chk("R9 wb idx zero", {60'h0, r_idx}, 64'h0);
      chk("R9 wb_en", {63'h0, r_wb_en}, 64'h1);
      run_op(8'hdb, 32'hf1, 64'h20, 16'h0, 64'h77, 64'h55, 4'd6);
      chk("R9 match writes", ram[4], 64'h77);
      run_op(8'hc3, 32'hf1, 64'h20, 16'h0, 64'hABCD_0000_0000_0099, 64'hFFFF_0000_0000_0077, 4'd6);
      chk("R9 word low-only compare", ram[4], 64'h99);
      chk("R9 word old zext", r_data, 64'h77);
   endtask

   task automatic t_illegal;
      logic [7:0]  opcs [6] = '{8'hcb, 8'hd3, 8'h7b, 8'hc3, 8'hdb, 8'hc3};
      logic [31:0] imms [6] = '{32'h01, 32'h01, 32'h00, 32'he0, 32'h10, 32'h100};
      preload(4'd5, 64'h5A5A_5A5A_5A5A_5A5A);
      for (int k = 0; k < 6; k++) begin
         run_op(opcs[k], imms[k], 64'h28, 16'h0, 64'h1, 64'h0, 4'd1);
         chk((k < 3) ? "R2 illegal opcode flag" : "R3 illegal imm flag", {63'h0, r_ill}, 64'h1);
         chk("R2 illegal fast done", r_cyc, 1);
         chk("R2 illegal no wb", {63'h0, r_wb_en}, 64'h0);
         chk("R3 illegal memory intact", ram[5], 64'h5A5A_5A5A_5A5A_5A5A);
      end
      run_op(8'hdb, 32'hf0, 64'h28, 16'h0, 64'h1, 64'h5A5A_5A5A_5A5A_5A5A, 4'd1);
      chk("R3 cmpx without fetch", {63'h0, r_ill}, 64'h1);
      chk("R3 cmpx without fetch intact", ram[5], 64'h5A5A_5A5A_5A5A_5A5A);
   endtask

   task automatic t_misalign;
      run_op(8'hdb, 32'h00, 64'h28, 16'h4, 64'h1, 64'h0, 4'd1);
      chk("R4 dw misalign flag", {63'h0, r_mis}, 64'h1);
      chk("R4 dw misalign intact", ram[5], 64'h5A5A_5A5A_5A5A_5A5A);
      chk("R4 misalign no illegal", {63'h0, r_ill}, 64'h0);
      run_op(8'hc3, 32'h01, 64'h2A, 16'h0, 64'h1, 64'h0, 4'd1);
      chk("R4 word misalign flag", {63'h0, r_mis}, 64'h1);
      chk("R4 word misalign no wb", {63'h0, r_wb_en}, 64'h0);
      run_op(8'hcb, 32'h10, 64'h29, 16'h0, 64'h1, 64'h0, 4'd1);
      chk("R10 both faults illegal", {63'h0, r_ill}, 64'h1);
      chk("R10 both faults no misalign", {63'h0, r_mis}, 64'h0);
   endtask

   task automatic t_busy_drop;
      int dones;
      preload(4'd6, 64'h10);
      preload(4'd8, 64'h0BAD);
      @(negedge clk);
      req_opcode = 8'hdb; req_imm = 32'h00; req_base = 64'h30; req_off = 16'h0;
      req_src = 64'h1; req_r0 = 64'h0; req_src_idx = 4'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      dones = 0;
      for (int c = 1; c < 10; c++) begin
         if (done) dones = dones + 1;
         if (c == 3) begin
            req_base = 64'h40; req_src = 64'hFFFF; req_valid = 1'b1;
         end
         if (c == 5) req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk("R1 one completion only", dones, 1);
      chk("R1 dropped request line intact", ram[8], 64'h0BAD);
      chk("R1 first request applied", ram[6], 64'h11);
      chk("R1 idle afterwards", {63'h0, busy}, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_add_dw();
      t_word_ops();
      t_dw_ops();
      t_xchg();
      t_cmpx();
      t_illegal();
      t_misalign();
      t_busy_drop();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule